// File: doc/BRIEF.md
# Masked Content Addressable Memory

This block holds a small table of words, each with a valid flag, and searches all of them at once against a key. A per-bit mask picks which bit positions take part. Mask bit 1 means the position is compared. Mask bit 0 means the position is forced to zero in both the key and the entry before the comparison.

Besides equality, the block performs ordered searches on the masked fields, treated as unsigned numbers: entries below the key, entries above the key, the nearest entry below it and the nearest entry above it. The result of the latest search is held in registers. It consists of a hit vector with one bit per entry, the full stored word of the lowest-index hit, and a flag that says whether anything was hit.

Words are loaded through a simple write port. A write that lands in the same cycle as a search takes effect after that search.

Top module: `masked_cam`

## Requirements
- R1: After reset all entries are invalid and `hitVec`, `hitWord` and `hitAny` are all zero.
- R2: A write with `wrEn`=1 stores `wrData` and the valid flag `wrValid` at `wrAddr`. An entry whose valid flag is 0 is never set in `hitVec`.
- R3: Only key bits whose `srchMask` bit is 1 take part in a search. Masked-off bits of both the key and the entries are treated as zero, and the masked fields are compared as unsigned values.
- R4: Op code 0 (equal) sets `hitVec[i]` for every valid entry i whose masked value equals the masked key.
- R5: Op code 1 (below) sets `hitVec[i]` for every valid entry whose masked value is less than the masked key. Op code 2 (above) sets it for every valid entry whose masked value is greater.
- R6: Op code 3 (nearest below) sets exactly one bit, at the entry with the largest masked value that is less than the masked key. If no such entry exists, it sets none.
- R7: Op code 4 (nearest above) sets exactly one bit, at the entry with the smallest masked value that is greater than the masked key. If no such entry exists, it sets none.
- R8: In a nearest search, a tie between equal candidates goes to the lowest index. `hitWord` is the full stored word of the lowest set bit of `hitVec`, or zero when none is set. `hitAny` is 1 exactly when `hitVec` is nonzero.
- R9: The results change on the clock edge that samples `srchValid`=1 and are visible from the next cycle on. Without a search they hold, even while entries are written.
- R10: A search and a write in the same cycle: the search sees the contents from before that write.
- R11: Op codes 5, 6 and 7 give an empty result: `hitVec`=0, `hitWord`=0 and `hitAny`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Entry index to write |
| wrData | input | 16 | Word to store |
| wrValid | input | 1 | Valid flag stored with the word |
| srchValid | input | 1 | Start a search this cycle |
| srchOp | input | 3 | Search kind: 0 equal, 1 below, 2 above, 3 nearest below, 4 nearest above |
| srchKey | input | 16 | Search key |
| srchMask | input | 16 | Per-bit compare enable (1 = compared) |
| hitVec | output | 16 | One bit per entry hit by the latest search |
| hitWord | output | 16 | Stored word of the lowest-index hit |
| hitAny | output | 1 | At least one entry was hit |

## Verification
The situations hardest to reach from the ports are these:
- a nearest search where two entries hold the same masked value and both are the best candidate;
- a search that collides with a write to the very entry it would match.

The stimulus builds the tie on purpose. It loads two identical words at indices 1 and 3 and keeps every other valid word far away, so a nearest-above search from just below that value leaves both entries as candidates. It also issues searches in the same cycle as writes that overwrite or invalidate the matching entry. A long run then mixes random masks, keys, op codes and writes, including the unused op codes. A reference model updated at every edge compares all outputs each cycle.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [2:0] {
    OP_EQ  = 3'd0,
    OP_LT  = 3'd1,
    OP_GT  = 3'd2,
    OP_NLO = 3'd3,
    OP_NHI = 3'd4
  } camOpE;

  typedef struct packed {
    logic search;
    logic selEq;
    logic selLt;
    logic selGt;
    logic selNlo;
    logic selNhi;
    logic write;
  } camStrobesT;

endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
(
  input  logic       srchValid,
  input  logic [2:0] srchOp,
  input  logic       wrEn,
  output camStrobesT strb
);

  always_comb begin
    strb        = '0;
    strb.search = srchValid;
    strb.write  = wrEn;
    if (srchValid) begin
      case (srchOp)
        OP_EQ:   strb.selEq  = 1'b1;
        OP_LT:   strb.selLt  = 1'b1;
        OP_GT:   strb.selGt  = 1'b1;
        OP_NLO:  strb.selNlo = 1'b1;
        OP_NHI:  strb.selNhi = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cam_data.sv
module cam_data
  import cam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  camStrobesT       strb,
  input  logic [IDXW-1:0]  wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrValid,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] mask,
  output logic [DEPTH-1:0] matchVec,
  output logic [WIDTH-1:0] selWord,
  output logic             found
);

  logic [WIDTH-1:0] memData [DEPTH];
  logic [DEPTH-1:0] memValid;
  logic [WIDTH-1:0] entMask [DEPTH];
  logic [WIDTH-1:0] keyMask;
  logic [DEPTH-1:0] hitEq, hitLt, hitGt;

  assign keyMask = key & mask;

  // Parallel per-entry comparators
  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign entMask[g] = memData[g] & mask;
    assign hitEq[g]   = memValid[g] && (entMask[g] == keyMask);
    assign hitLt[g]   = memValid[g] && (entMask[g] <  keyMask);
    assign hitGt[g]   = memValid[g] && (entMask[g] >  keyMask);
  end

  // Nearest-neighbour reduction; strict compare keeps lowest index on ties
  logic            nloHave, nhiHave;
  logic [IDXW-1:0] nloIdx, nhiIdx;
  logic [WIDTH-1:0] nloVal, nhiVal;

  always_comb begin
    nloHave = 1'b0; nloIdx = '0; nloVal = '0;
    nhiHave = 1'b0; nhiIdx = '0; nhiVal = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hitLt[i] && (!nloHave || entMask[i] > nloVal)) begin
        nloHave = 1'b1; nloIdx = IDXW'(i); nloVal = entMask[i];
      end
      if (hitGt[i] && (!nhiHave || entMask[i] < nhiVal)) begin
        nhiHave = 1'b1; nhiIdx = IDXW'(i); nhiVal = entMask[i];
      end
    end
  end

  logic [DEPTH-1:0] nextVec;
  always_comb begin
    nextVec = '0;
    if (strb.selEq)       nextVec = hitEq;
    else if (strb.selLt)  nextVec = hitLt;
    else if (strb.selGt)  nextVec = hitGt;
    else if (strb.selNlo) nextVec = nloHave ? (DEPTH'(1) << nloIdx) : '0;
    else if (strb.selNhi) nextVec = nhiHave ? (DEPTH'(1) << nhiIdx) : '0;
  end

  // Lowest-index priority pick for the returned word
  logic [IDXW-1:0]  pickIdx;
  logic [WIDTH-1:0] nextWord;
  always_comb begin
    pickIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (nextVec[i]) pickIdx = IDXW'(i);
    end
    nextWord = (|nextVec) ? memData[pickIdx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid <= '0;
      matchVec <= '0;
      selWord  <= '0;
      found    <= 1'b0;
    end else begin
      if (strb.search) begin
        matchVec <= nextVec;
        selWord  <= nextWord;
        found    <= |nextVec;
      end
      if (strb.write) memValid[wrAddr] <= wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.write) memData[wrAddr] <= wrData;
  end

  // R6 / R7: nearest searches report at most one entry
  p_nearest_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.search && (strb.selNlo || strb.selNhi)) |=> $onehot0(matchVec));

  // R8: flag agrees with the vector
  p_found_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    found == (matchVec != '0));

  // R9: results hold without a search
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.search |=> ($stable(matchVec) && $stable(selWord) && $stable(found)));

  // R2: no hit on an entry that was invalid when searched
  p_invalid_never_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.search |=> ((matchVec & ~$past(memValid)) == '0));

  // R11: unused op codes give an empty result
  p_bad_op_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.search && !(strb.selEq || strb.selLt || strb.selGt || strb.selNlo || strb.selNhi))
    |=> (matchVec == '0 && !found && selWord == '0));

endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDXW-1:0]  wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrValid,
  input  logic             srchValid,
  input  logic [2:0]       srchOp,
  input  logic [WIDTH-1:0] srchKey,
  input  logic [WIDTH-1:0] srchMask,
  output logic [DEPTH-1:0] hitVec,
  output logic [WIDTH-1:0] hitWord,
  output logic             hitAny
);

  camStrobesT strb;

  cam_ctrl i_ctrl (
    .srchValid (srchValid),
    .srchOp    (srchOp),
    .wrEn      (wrEn),
    .strb      (strb)
  );

  cam_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrValid  (wrValid),
    .key      (srchKey),
    .mask     (srchMask),
    .matchVec (hitVec),
    .selWord  (hitWord),
    .found    (hitAny)
  );

endmodule

// File: tb/test_masked_cam.sv
module test_masked_cam;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, wrValid, srchValid;
  logic [3:0]  wrAddr;
  logic [15:0] wrData, srchKey, srchMask;
  logic [2:0]  srchOp;
  logic [15:0] hitVec, hitWord;
  logic        hitAny;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curTag = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  masked_cam i_masked_cam (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrValid(wrValid), .srchValid(srchValid), .srchOp(srchOp), .srchKey(srchKey),
    .srchMask(srchMask), .hitVec(hitVec), .hitWord(hitWord), .hitAny(hitAny)
  );

  // Reference model
  logic [15:0] refData [16];
  logic        refValid [16];
  logic [15:0] expVec, expWord;
  logic        expAny;
  string       expTag = "R1";

  always @(posedge clk) begin : model
    logic [15:0] km, em, vec, sel, bestVal;
    int best;
    if (!rstN) begin
      expVec <= '0; expWord <= '0; expAny <= 1'b0; expTag <= "R1";
      for (int i = 0; i < 16; i++) refValid[i] <= 1'b0;
    end else begin
      if (srchValid) begin
        km = srchKey & srchMask;
        vec = '0; best = -1; bestVal = '0;
        for (int i = 0; i < 16; i++) begin
          if (refValid[i]) begin
            em = refData[i] & srchMask;
            case (srchOp)
              3'd0: if (em == km) vec[i] = 1'b1;
              3'd1: if (em < km) vec[i] = 1'b1;
              3'd2: if (em > km) vec[i] = 1'b1;
              3'd3: if (em < km && (best < 0 || em > bestVal)) begin best = i; bestVal = em; end
              3'd4: if (em > km && (best < 0 || em < bestVal)) begin best = i; bestVal = em; end
              default: ;
            endcase
          end
        end
        if (best >= 0) vec[best] = 1'b1;
        sel = '0;
        for (int i = 15; i >= 0; i--) if (vec[i]) sel = refData[i];
        expVec <= vec; expWord <= sel; expAny <= (vec != 0); expTag <= curTag;
      end
      if (wrEn) begin
        refData[wrAddr]  <= wrData;
        refValid[wrAddr] <= wrValid;
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    checks++;
    if (hitVec !== expVec || hitWord !== expWord || hitAny !== expAny) begin
      errors++;
      $display("FAIL %s vec=%h/%h word=%h/%h any=%b/%b (actual/expected)",
               expTag, hitVec, expVec, hitWord, expWord, hitAny, expAny);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0; srchValid = 1'b0;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d, logic v);
    @(negedge clk);
    srchValid = 1'b0;
    wrEn = 1'b1; wrAddr = a; wrData = d; wrValid = v;
  endtask

  task automatic srch(string tag, logic [2:0] op, logic [15:0] k, logic [15:0] m);
    @(negedge clk);
    wrEn = 1'b0;
    curTag = tag; srchValid = 1'b1; srchOp = op; srchKey = k; srchMask = m;
  endtask

  task automatic both(string tag, logic [2:0] op, logic [15:0] k, logic [15:0] m,
                      logic [3:0] a, logic [15:0] d, logic v);
    @(negedge clk);
    curTag = tag; srchValid = 1'b1; srchOp = op; srchKey = k; srchMask = m;
    wrEn = 1'b1; wrAddr = a; wrData = d; wrValid = v;
  endtask

  function automatic string tagForOp(logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1, 3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrValid = 1'b0; srchValid = 1'b0;
    wrAddr = '0; wrData = '0; srchKey = '0; srchMask = '0; srchOp = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state is compared on the idle cycles and an empty-table search
    idle(2);
    srch("R1", 3'd2, 16'h0000, 16'hFFFF);
    idle(1);

    // R2: load the table, entry 6 invalid; 1 and 3 identical for the R8 tie
    wr(4'd0, 16'h1234, 1'b1);
    wr(4'd1, 16'h0050, 1'b1);
    wr(4'd2, 16'h00A0, 1'b1);
    wr(4'd3, 16'h0050, 1'b1);
    wr(4'd4, 16'h8000, 1'b1);
    wr(4'd5, 16'hFFFF, 1'b1);
    wr(4'd6, 16'h00A0, 1'b0);
    for (int i = 7; i < 16; i++) wr(4'(i), 16'h2000 + 16'(i) * 16'h0100, 1'b1);
    idle(1);

    srch("R2", 3'd0, 16'h00A0, 16'hFFFF);   // entry 6 must stay out
    srch("R4", 3'd0, 16'h0050, 16'hFFFF);   // hits 1 and 3
    srch("R3", 3'd0, 16'hFF54, 16'h00F0);   // only nibble [7:4] compared
    srch("R3", 3'd1, 16'h0F00, 16'h0F00);
    srch("R5", 3'd1, 16'h00A0, 16'hFFFF);
    srch("R5", 3'd2, 16'h2A00, 16'hFFFF);
    srch("R6", 3'd3, 16'h00A0, 16'hFFFF);   // nearest below -> 0x0050 at index 1
    srch("R6", 3'd3, 16'h0000, 16'hFFFF);   // nothing below
    srch("R7", 3'd4, 16'hFFFF, 16'hFFFF);   // nothing above
    srch("R8", 3'd4, 16'h0040, 16'hFFFF);   // tie 1 vs 3, index 1 wins
    srch("R8", 3'd3, 16'h0060, 16'hFFFF);
    srch("R11", 3'd5, 16'h0050, 16'hFFFF);
    srch("R11", 3'd7, 16'h0000, 16'h0000);

    // R9: results hold across idle cycles and writes
    srch("R9", 3'd0, 16'h1234, 16'hFFFF);
    wr(4'd0, 16'h0000, 1'b1);
    wr(4'd9, 16'h1234, 1'b1);
    idle(4);

    // R10: search sees contents from before a same-cycle write
    both("R10", 3'd0, 16'h1234, 16'hFFFF, 4'd9, 16'h0001, 1'b1);
    srch("R10", 3'd0, 16'h1234, 16'hFFFF);
    both("R10", 3'd4, 16'h0040, 16'hFFFF, 4'd1, 16'h0000, 1'b0);
    srch("R10", 3'd4, 16'h0040, 16'hFFFF);
    idle(2);

    // Random mixed traffic
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      @(negedge clk);
      srchValid = ($urandom_range(0, 3) != 0);
      srchOp = op; curTag = tagForOp(op);
      srchKey = 16'($urandom);
      srchMask = ($urandom_range(0, 2) == 0) ? 16'hFFFF : 16'($urandom);
      wrEn = ($urandom_range(0, 2) == 0);
      wrAddr = 4'($urandom); wrValid = ($urandom_range(0, 4) != 0);
      wrData = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 15)) : 16'($urandom);
    end
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule